// File: doc/BRIEF.md
# Four-Bit Multifunction Arithmetic-Logic Slice

This block is a purely combinational 4-bit arithmetic-logic slice. It takes two operands, a carry input, a mode bit and a 4-bit function code, and returns a 4-bit result with a carry output. The mode bit picks one of two groups of sixteen operations, so five control bits select 32 operations in total. Both groups use the same function code. All data is active high.

In arithmetic mode the result is the sum of two addends plus the carry input. Each addend is formed from the operands according to the function code. In logic mode the same two addends are combined without any carry, and the carry input has no effect. The slice has three more outputs. One flags a result of all ones, which gives an equality test when the slice subtracts. The other two are group propagate and group generate terms, which an external carry-lookahead unit can use. The slice has no clock and holds no state.

Top module: `alu4_slice`

## Requirements
- R1: With `logic_mode`=1, `result` is given by `func_sel`: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 all zeros, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 all ones, 1101 A|~B, 1110 A|B, 1111 A.
- R2: With `logic_mode`=0, `result` is the low 4 bits of X+Y+`carry_in`. X is given by `func_sel[1:0]`: 00 A, 01 A|B, 10 A|~B, 11 all ones. Y is given by `func_sel[3:2]`: 00 zero, 01 A&~B, 10 A&B, 11 A.
- R3: With `logic_mode`=0, `carry_out` is bit 4 of the 5-bit unsigned sum X+Y+`carry_in`. For example, code 1001 gives A+B with carry, and code 0110 gives A-B-1+cin with `carry_out`=1 meaning no borrow.
- R4: With `logic_mode`=1, `carry_out` is 0 and `carry_in` has no effect on any output.
- R5: `all_ones` is 1 exactly when every bit of `result` is 1.
- R6: `grp_gen` is 1 when X+Y (without carry input) exceeds 15. `grp_prop` is 1 when X+Y is 15 or more. Both are reported in either mode.
- R7: With `logic_mode`=0, `carry_out` equals `grp_gen | (grp_prop & carry_in)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| carry_in | input | 1 | Carry input, active high, used in arithmetic mode only |
| logic_mode | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| func_sel | input | 4 | Function code, shared by both modes |
| result | output | 4 | Function result |
| carry_out | output | 1 | Carry from bit 3 in arithmetic mode, else 0 |
| all_ones | output | 1 | Result is all ones |
| grp_prop | output | 1 | Group propagate of the addend pair |
| grp_gen | output | 1 | Group generate of the addend pair |

## Verification
The hardest case is an addend pair that sums to exactly 15. Here the propagate term is set but the generate term is not, so `carry_out` depends entirely on `carry_in`. Only a narrow set of operand pairs reaches this case for each function code. The stimulus reaches it through the subtract code with equal operands, where A-A-1 gives all ones, and also through a sweep of every one of the 16384 input combinations against a model built from the requirement tables.

// File: rtl/alu4_slice.sv
`timescale 1ns/1ps
module alu4_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic         logic_mode,
  input  logic [3:0]   func_sel,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         all_ones,
  output logic         grp_prop,
  output logic         grp_gen
);

  logic [W-1:0] term_x;
  logic [W-1:0] term_y;
  logic [W:0]   base_sum;
  logic [W:0]   full_sum;

  // two addends, each a per-bit mux of the operands
  assign term_x = op_a
                | (op_b  & {W{func_sel[0]}})
                | (~op_b & {W{func_sel[1]}});
  assign term_y = (op_a & ~op_b & {W{func_sel[2]}})
                | (op_a &  op_b & {W{func_sel[3]}});

  assign base_sum = {1'b0, term_x} + {1'b0, term_y};
  assign full_sum = base_sum + {{W{1'b0}}, carry_in};

  assign grp_gen  = base_sum[W];
  assign grp_prop = base_sum[W] | (&base_sum[W-1:0]);

  // carry-free combination of the addends gives the logic group
  assign result    = logic_mode ? ~(term_x ^ term_y) : full_sum[W-1:0];
  assign carry_out = ~logic_mode & full_sum[W];
  assign all_ones  = &result;

endmodule

// File: rtl/alu4_slice_chk.sv
`timescale 1ns/1ps
module alu4_slice_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         carry_in,
  input logic         logic_mode,
  input logic [3:0]   func_sel,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         all_ones,
  input logic         grp_prop,
  input logic         grp_gen
);

  logic [W:0] add_ref;
  logic [W:0] sub_ref;

  always_comb begin
    add_ref = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
    sub_ref = {1'b0, op_a} + {1'b0, ~op_b} + {{W{1'b0}}, carry_in};
    AST_LOGIC_XOR: assert (!(logic_mode && func_sel == 4'b0110) || result == (op_a ^ op_b)) else $error("xor path"); // R1
    AST_LOGIC_PASS: assert (!(logic_mode && func_sel == 4'b1111) || result == op_a) else $error("pass path"); // R1
    AST_ADD_PATH: assert (!(!logic_mode && func_sel == 4'b1001) || {carry_out, result} == add_ref) else $error("add path"); // R3
    AST_SUB_PATH: assert (!(!logic_mode && func_sel == 4'b0110) || {carry_out, result} == sub_ref) else $error("sub path"); // R2
    AST_LOGIC_NO_CARRY: assert (!logic_mode || !carry_out) else $error("carry in logic mode"); // R4
    AST_ALL_ONES: assert (all_ones == (result == {W{1'b1}})) else $error("all ones flag"); // R5
    AST_GEN_IMPLIES_PROP: assert (!grp_gen || grp_prop) else $error("gen without prop"); // R6
    AST_LOOKAHEAD: assert (logic_mode || carry_out == (grp_gen | (grp_prop & carry_in))) else $error("lookahead"); // R7
  end

endmodule

bind alu4_slice alu4_slice_chk #(.W(W)) i_alu4_slice_chk (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .logic_mode(logic_mode),
  .func_sel(func_sel), .result(result), .carry_out(carry_out),
  .all_ones(all_ones), .grp_prop(grp_prop), .grp_gen(grp_gen)
);

// File: tb/test_alu4_slice.sv
`timescale 1ns/1ps
module test_alu4_slice;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] op_a = '0, op_b = '0, func_sel = '0;
  logic       carry_in = 1'b0, logic_mode = 1'b0;
  logic [3:0] result;
  logic       carry_out, all_ones, grp_prop, grp_gen;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  alu4_slice i_alu4_slice (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .logic_mode(logic_mode),
    .func_sel(func_sel), .result(result), .carry_out(carry_out),
    .all_ones(all_ones), .grp_prop(grp_prop), .grp_gen(grp_gen)
  );

  function automatic logic [3:0] ref_logic(input logic [3:0] a, b, s);
    case (s)
      4'b0000: return ~a;
      4'b0001: return ~(a | b);
      4'b0010: return ~a & b;
      4'b0011: return 4'b0000;
      4'b0100: return ~(a & b);
      4'b0101: return ~b;
      4'b0110: return a ^ b;
      4'b0111: return a & ~b;
      4'b1000: return ~a | b;
      4'b1001: return ~(a ^ b);
      4'b1010: return b;
      4'b1011: return a & b;
      4'b1100: return 4'b1111;
      4'b1101: return a | ~b;
      4'b1110: return a | b;
      default: return a;
    endcase
  endfunction

  function automatic logic [4:0] ref_pair(input logic [3:0] a, b, s);
    logic [3:0] x, y;
    case (s[1:0])
      2'b00: x = a;
      2'b01: x = a | b;
      2'b10: x = a | ~b;
      default: x = 4'b1111;
    endcase
    case (s[3:2])
      2'b00: y = 4'b0000;
      2'b01: y = a & ~b;
      2'b10: y = a & b;
      default: y = a;
    endcase
    return {1'b0, x} + {1'b0, y};
  endfunction

  task automatic apply(input logic m, input logic [3:0] s, input logic c,
                       input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    logic_mode = m; func_sel = s; carry_in = c; op_a = a; op_b = b;
    #2;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (m=%b s=%b c=%b a=%h b=%h)",
               req, act, exp, logic_mode, func_sel, carry_in, op_a, op_b);
    end
  endtask

  task automatic t_idle;
    apply(1'b0, 4'b0000, 1'b0, 4'h0, 4'h0);
    check("R2 idle result", {4'h0, result}, 8'h00);
    check("R3 idle carry", {7'd0, carry_out}, 8'h00);
  endtask

  task automatic t_add;
    apply(1'b0, 4'b1001, 1'b1, 4'h9, 4'h8);
    check("R3 add 9+8+1", {3'd0, carry_out, result}, 8'h12);
    apply(1'b0, 4'b1001, 1'b0, 4'h3, 4'h4);
    check("R3 add 3+4", {3'd0, carry_out, result}, 8'h07);
  endtask

  task automatic t_sub;
    apply(1'b0, 4'b0110, 1'b1, 4'h5, 4'h3);
    check("R3 sub 5-3 no borrow", {3'd0, carry_out, result}, 8'h12);
    apply(1'b0, 4'b0110, 1'b1, 4'h3, 4'h5);
    check("R3 sub 3-5 borrow", {3'd0, carry_out, result}, 8'h0e);
    apply(1'b0, 4'b1111, 1'b0, 4'h0, 4'h7);
    check("R2 decrement zero", {3'd0, carry_out, result}, 8'h0f);
  endtask

  task automatic t_compare;
    apply(1'b0, 4'b0110, 1'b0, 4'hA, 4'hA);
    check("R5 equal compare", {7'd0, all_ones}, 8'h01);
    check("R6 prop at sum 15", {6'd0, grp_prop, grp_gen}, 8'h02);
    check("R7 carry from cin=0", {7'd0, carry_out}, 8'h00);
    apply(1'b0, 4'b0110, 1'b1, 4'hA, 4'hA);
    check("R7 carry from cin=1", {3'd0, carry_out, result}, 8'h10);
    apply(1'b0, 4'b0110, 1'b0, 4'hA, 4'hB);
    check("R5 unequal compare", {7'd0, all_ones}, 8'h00);
  endtask

  task automatic t_logic_cin;
    apply(1'b1, 4'b1100, 1'b1, 4'h3, 4'h6);
    check("R4 logic carry zero", {3'd0, carry_out, result}, 8'h0f);
    apply(1'b1, 4'b1001, 1'b0, 4'h3, 4'h6);
    check("R4 cin=0 xnor", {3'd0, carry_out, result}, 8'h0a);
    apply(1'b1, 4'b1001, 1'b1, 4'h3, 4'h6);
    check("R4 cin=1 xnor", {3'd0, carry_out, result}, 8'h0a);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
              logic [4:0] pr, tot;
              logic [3:0] ef;
              logic       ec;
              apply(m[0], s[3:0], c[0], a[3:0], b[3:0]);
              pr  = ref_pair(a[3:0], b[3:0], s[3:0]);
              tot = pr + {4'd0, c[0]};
              ef  = m[0] ? ref_logic(a[3:0], b[3:0], s[3:0]) : tot[3:0];
              ec  = m[0] ? 1'b0 : tot[4];
              check(m[0] ? "R1 R4 R5 R6 sweep" : "R2 R3 R5 R6 R7 sweep",
                    {result, carry_out, all_ones, grp_prop, grp_gen},
                    {ef, ec, &ef, pr >= 5'd15, pr[4]});
            end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_idle();
    t_add();
    t_sub();
    t_compare();
    t_logic_cin();
    t_sweep();
    finish_run();
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule